// File: doc/BRIEF.md
# Bridge Error Injection and Reporting Status

This block holds the advanced error status state of one bridge function and lets software fake error detections. Software uses a register port to write two injection registers, one for uncorrectable errors and one for correctable errors. Each bit set in an injection register acts as if the hardware had detected that error. The block records the error in the matching status register. It applies the mask and severity settings and raises an error message request toward the root. No packet parsing or message transmission happens inside the block.

Message requests leave on a valid/ready stream. A request stays pending until the receiver takes it. `msg_valid` stays high while `msg_ready` is low, and the message kind shown may only move up in priority while it waits. Requests of the same kind merge while pending. The block also keeps four header-log dwords that software can write and read back, so that a captured header can be faked. Reads are combinational from `rd_addr`.

Register word addresses:

| Address | Register |
|---------|----------|
| 0 | uncorrectable status |
| 1 | uncorrectable mask |
| 2 | uncorrectable severity |
| 3 | correctable status |
| 4 | correctable mask |
| 5 | first-error pointer |
| 6 | uncorrectable injection |
| 7 | correctable injection |
| 8 to 11 | header-log dwords 0 to 3 |

Top module: `aer_emu_core`

## Requirements
- R1: After reset, every register reads 0 and `msg_valid` is low.
- R2: A write of bit k to the correctable injection register (address 7) sets bit k of correctable status (address 3). The status bit is visible after the second rising edge, counted from the write edge. An unmasked bit raises a correctable request.
- R3: A write of bit k (k below 31) to the uncorrectable injection register (address 6) sets bit k of uncorrectable status (address 0) at the same point in time.
- R4: A masked error still sets its status bit, but it raises no message request.
- R5: For an unmasked uncorrectable error, severity bit k decides the request kind: 1 gives fatal (`msg_type`=2) and 0 gives non-fatal (`msg_type`=1).
- R6: Bit 31 of the uncorrectable injection register is the advisory qualifier.
  - When bit 31 is set together with other bits, those status bits are set and correctable status bit 13 is set. A correctable request (`msg_type`=0) is raised only when correctable mask bit 13 is clear. No fatal or non-fatal request is raised.
  - Bit 31 written alone changes nothing.
- R7: Both status registers are write-one-to-clear. When a clear and an injection hit the same bit on the same edge, the injection wins.
- R8: The first-error pointer reads with the valid flag in bit 31 and the index in bits 4:0.
  - While the pointer is not valid, it takes the lowest-numbered unmasked uncorrectable bit that is newly set, and becomes valid.
  - It holds while valid.
  - It becomes invalid when software clears the status bit it points to.
- R9: Header-log dwords 8 to 11 read back what was last written to them.
- R10: Message stream rules:
  - `msg_valid` holds until `msg_valid && msg_ready`.
  - Fatal is offered before non-fatal, and non-fatal before correctable.
  - Each acceptance retires one kind.
- R11: Injection bits clear themselves. An injection register reads 0 one cycle after the edge that takes the injection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| msg_valid | output | 1 | Error message request pending |
| msg_ready | input | 1 | Receiver accepts the offered request |
| msg_type | output | 2 | 0 correctable, 1 non-fatal, 2 fatal |

## Verification
The bench stalls the message stream while a fatal request joins a pending non-fatal one. A design with inverted priority, or one that loses the waiting request, would show the wrong kind or drop `msg_valid` early. It times a status clear on the same edge as an injection of that bit; a design that lets the clear win leaves the bit at zero. Advisory injections are run with the advisory mask bit open and closed, and also with the qualifier written alone. This catches a design that raises a non-fatal request, skips correctable status bit 13, or treats the qualifier itself as an error. The first-error pointer is checked across masked errors, later errors and a clear of the bit it points to; a design that overwrites or never releases the pointer shows a wrong index or valid flag.

// File: rtl/aer_emu_pkg.sv
package aer_emu_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_UE_STAT = 4'd0;
  localparam logic [ADDR_W-1:0] A_UE_MASK = 4'd1;
  localparam logic [ADDR_W-1:0] A_UE_SEV  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CE_STAT = 4'd3;
  localparam logic [ADDR_W-1:0] A_CE_MASK = 4'd4;
  localparam logic [ADDR_W-1:0] A_FEP     = 4'd5;
  localparam logic [ADDR_W-1:0] A_UE_EMU  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CE_EMU  = 4'd7;
  localparam logic [ADDR_W-1:0] A_HDR0    = 4'd8;

  typedef enum logic [1:0] {
    MSG_COR   = 2'd0,
    MSG_NF    = 2'd1,
    MSG_FATAL = 2'd2
  } msg_kind_e;
endpackage

// File: rtl/aer_inject.sv
module aer_inject #(
  parameter int unsigned DW        = 32,
  parameter int unsigned ADV_BIT   = 31,
  parameter int unsigned ADVNF_BIT = 13,
  localparam int unsigned IW       = $clog2(DW)
) (
  input  logic [DW-1:0] ue_emu,
  input  logic [DW-1:0] ce_emu,
  input  logic [DW-1:0] ue_stat,
  input  logic [DW-1:0] ue_mask,
  input  logic [DW-1:0] ue_sev,
  input  logic [DW-1:0] ce_mask,
  output logic [DW-1:0] ue_set,
  output logic [DW-1:0] ce_set,
  output logic          req_cor,
  output logic          req_nf,
  output logic          req_fatal,
  output logic          cand_valid,
  output logic [IW-1:0] cand_idx
);
  logic [DW-1:0] err_bits, open_bits, fresh, adv_vec;
  logic          adv;

  always_comb begin
    err_bits          = ue_emu;
    err_bits[ADV_BIT] = 1'b0;
    adv               = ue_emu[ADV_BIT] & (|err_bits);
    open_bits         = err_bits & ~ue_mask;
    adv_vec           = '0;
    adv_vec[ADVNF_BIT] = adv;

    ue_set    = err_bits;
    ce_set    = ce_emu | adv_vec;
    req_fatal = !adv && (|(open_bits & ue_sev));
    req_nf    = !adv && (|(open_bits & ~ue_sev));
    req_cor   = (|(ce_emu & ~ce_mask)) | (adv & ~ce_mask[ADVNF_BIT]);

    fresh      = open_bits & ~ue_stat;
    cand_valid = |fresh;
    cand_idx   = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (fresh[i]) cand_idx = IW'(i);
    end
  end
endmodule

// File: rtl/aer_msg_arb.sv
module aer_msg_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_cor,
  input  logic       req_nf,
  input  logic       req_fatal,
  input  logic       msg_ready,
  output logic       msg_valid,
  output logic [1:0] msg_type
);
  import aer_emu_pkg::*;

  logic [2:0] pend_q, sel;
  msg_kind_e  kind;

  always_comb begin
    sel  = 3'b000;
    kind = MSG_COR;
    if (pend_q[2]) begin
      sel  = 3'b100;
      kind = MSG_FATAL;
    end else if (pend_q[1]) begin
      sel  = 3'b010;
      kind = MSG_NF;
    end else if (pend_q[0]) begin
      sel  = 3'b001;
    end
  end

  assign msg_valid = |pend_q;
  assign msg_type  = kind;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else pend_q <= (pend_q & ~((msg_valid && msg_ready) ? sel : 3'b000))
                 | {req_fatal, req_nf, req_cor};
  end
endmodule

// File: rtl/aer_hdr_log.sv
module aer_hdr_log #(
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 4,
  localparam int unsigned XW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [XW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [XW-1:0] rd_idx,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] hdr_q [WORDS];

  always_ff @(posedge clk) begin
    for (int g = 0; g < WORDS; g++) begin
      if (!rst_n) hdr_q[g] <= '0;
      else if (wr_en && wr_idx == XW'(g)) hdr_q[g] <= wr_data;
    end
  end

  assign rd_word = hdr_q[rd_idx];
endmodule

// File: rtl/aer_emu_core.sv
module aer_emu_core
  import aer_emu_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned ADV_BIT   = 31,
  parameter int unsigned ADVNF_BIT = 13,
  parameter int unsigned HDR_WORDS = 4,
  localparam int unsigned IW       = $clog2(DW),
  localparam int unsigned XW       = $clog2(HDR_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [1:0]        msg_type
);
  logic [DW-1:0] ue_stat_q, ue_mask_q, ue_sev_q, ce_stat_q, ce_mask_q;
  logic [DW-1:0] ue_emu_q, ce_emu_q;
  logic          fep_valid_q;
  logic [IW-1:0] fep_idx_q;

  logic [DW-1:0] ue_set, ce_set, ue_clr, ce_clr, fep_word, hdr_word;
  logic          req_cor, req_nf, req_fatal, cand_valid, fep_hit;
  logic [IW-1:0] cand_idx;
  logic          hdr_wr, hdr_rd;
  logic [ADDR_W-1:0] hdr_woff, hdr_roff;

  aer_inject #(.DW(DW), .ADV_BIT(ADV_BIT), .ADVNF_BIT(ADVNF_BIT)) u_inject (
    .ue_emu(ue_emu_q), .ce_emu(ce_emu_q), .ue_stat(ue_stat_q),
    .ue_mask(ue_mask_q), .ue_sev(ue_sev_q), .ce_mask(ce_mask_q),
    .ue_set(ue_set), .ce_set(ce_set), .req_cor(req_cor), .req_nf(req_nf),
    .req_fatal(req_fatal), .cand_valid(cand_valid), .cand_idx(cand_idx)
  );

  aer_msg_arb u_arb (
    .clk(clk), .rst_n(rst_n), .req_cor(req_cor), .req_nf(req_nf),
    .req_fatal(req_fatal), .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_type(msg_type)
  );

  assign hdr_woff = wr_addr - A_HDR0;
  assign hdr_roff = rd_addr - A_HDR0;
  assign hdr_wr = wr_en && (wr_addr >= A_HDR0)
                  && ({1'b0, wr_addr} < ({1'b0, A_HDR0} + (ADDR_W+1)'(HDR_WORDS)));
  assign hdr_rd = (rd_addr >= A_HDR0)
                  && ({1'b0, rd_addr} < ({1'b0, A_HDR0} + (ADDR_W+1)'(HDR_WORDS)));

  aer_hdr_log #(.DW(DW), .WORDS(HDR_WORDS)) u_hdr (
    .clk(clk), .rst_n(rst_n), .wr_en(hdr_wr), .wr_idx(hdr_woff[XW-1:0]),
    .wr_data(wr_data), .rd_idx(hdr_roff[XW-1:0]), .rd_word(hdr_word)
  );

  assign ue_clr  = (wr_en && wr_addr == A_UE_STAT) ? wr_data : '0;
  assign ce_clr  = (wr_en && wr_addr == A_CE_STAT) ? wr_data : '0;
  assign fep_hit = fep_valid_q && ue_clr[fep_idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ue_stat_q   <= '0;
      ce_stat_q   <= '0;
      ue_mask_q   <= '0;
      ue_sev_q    <= '0;
      ce_mask_q   <= '0;
      ue_emu_q    <= '0;
      ce_emu_q    <= '0;
      fep_valid_q <= 1'b0;
      fep_idx_q   <= '0;
    end else begin
      ue_stat_q <= (ue_stat_q & ~ue_clr) | ue_set;
      ce_stat_q <= (ce_stat_q & ~ce_clr) | ce_set;
      ue_emu_q  <= (wr_en && wr_addr == A_UE_EMU) ? wr_data : '0;
      ce_emu_q  <= (wr_en && wr_addr == A_CE_EMU) ? wr_data : '0;
      if (wr_en && wr_addr == A_UE_MASK) ue_mask_q <= wr_data;
      if (wr_en && wr_addr == A_UE_SEV)  ue_sev_q  <= wr_data;
      if (wr_en && wr_addr == A_CE_MASK) ce_mask_q <= wr_data;
      if (cand_valid && (!fep_valid_q || fep_hit)) begin
        fep_valid_q <= 1'b1;
        fep_idx_q   <= cand_idx;
      end else if (fep_hit) begin
        fep_valid_q <= 1'b0;
      end
    end
  end

  always_comb begin
    fep_word          = '0;
    fep_word[IW-1:0]  = fep_idx_q;
    fep_word[DW-1]    = fep_valid_q;
    case (rd_addr)
      A_UE_STAT: rd_data = ue_stat_q;
      A_UE_MASK: rd_data = ue_mask_q;
      A_UE_SEV:  rd_data = ue_sev_q;
      A_CE_STAT: rd_data = ce_stat_q;
      A_CE_MASK: rd_data = ce_mask_q;
      A_FEP:     rd_data = fep_word;
      A_UE_EMU:  rd_data = ue_emu_q;
      A_CE_EMU:  rd_data = ce_emu_q;
      default:   rd_data = hdr_rd ? hdr_word : '0;
    endcase
  end
endmodule

// File: rtl/aer_emu_chk.sv
module aer_emu_chk
  import aer_emu_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [1:0]        msg_type,
  input logic [DW-1:0]     ue_stat_q,
  input logic [DW-1:0]     ue_emu_q,
  input logic              fep_valid_q,
  input logic [IW-1:0]     fep_idx_q
);
  // R11
  emu_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_emu_q != '0 && !(wr_en && wr_addr == A_UE_EMU)) |=> (ue_emu_q == '0));

  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_UE_STAT) |=> ((ue_stat_q & $past(ue_stat_q)) == $past(ue_stat_q)));

  // R8
  fep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fep_valid_q && !(wr_en && wr_addr == A_UE_STAT)) |=> (fep_valid_q && $stable(fep_idx_q)));

  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid);

  // R10
  msg_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_type >= $past(msg_type)));
endmodule

bind aer_emu_core aer_emu_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type),
  .ue_stat_q(ue_stat_q), .ue_emu_q(ue_emu_q),
  .fep_valid_q(fep_valid_q), .fep_idx_q(fep_idx_q)
);

// File: tb/aer_emu_core_tb_top.sv
`timescale 1ns/1ps
module aer_emu_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [1:0]  msg_type;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  aer_emu_core dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type)
  );

  // behavioural reference model
  logic [31:0] m_reg [12];
  bit          m_fv;
  int          m_fp;
  bit          m_pend [3];

  function automatic logic [31:0] m_read(input logic [3:0] a);
    if (a == 4'd5) return {m_fv, 26'd0, m_fp[4:0]};
    if (a > 4'd11) return 32'd0;
    return m_reg[a];
  endfunction

  function automatic int m_top();
    for (int k = 2; k >= 0; k--) if (m_pend[k]) return k;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 12; i++) m_reg[i] = 0;
      m_fv = 0; m_fp = 0;
      for (int k = 0; k < 3; k++) m_pend[k] = 0;
    end else begin
      logic [31:0] ub, fresh, uemu, cemu;
      bit adv, hit, rq [3];
      int tp, low;
      uemu = m_reg[6]; cemu = m_reg[7];
      ub = uemu; ub[31] = 0;
      adv = uemu[31] && ub != 0;
      fresh = ub & ~m_reg[1] & ~m_reg[0];
      rq[2] = !adv && ((ub & ~m_reg[1] & m_reg[2]) != 0);
      rq[1] = !adv && ((ub & ~m_reg[1] & ~m_reg[2]) != 0);
      rq[0] = ((cemu & ~m_reg[4]) != 0) || (adv && !m_reg[4][13]);
      tp = m_top();
      if (tp >= 0 && msg_ready) m_pend[tp] = 0;
      for (int k = 0; k < 3; k++) if (rq[k]) m_pend[k] = 1;
      hit = m_fv && wr_en && wr_addr == 4'd0 && wr_data[m_fp];
      low = -1;
      for (int i = 31; i >= 0; i--) if (fresh[i]) low = i;
      if (low >= 0 && (!m_fv || hit)) begin m_fv = 1; m_fp = low; end
      else if (hit) m_fv = 0;
      if (wr_en && wr_addr == 4'd0) m_reg[0] &= ~wr_data;
      if (wr_en && wr_addr == 4'd3) m_reg[3] &= ~wr_data;
      m_reg[0] |= ub;
      m_reg[3] |= cemu;
      if (adv) m_reg[3][13] = 1;
      m_reg[6] = 0; m_reg[7] = 0;
      if (wr_en && wr_addr != 4'd0 && wr_addr != 4'd3 && wr_addr != 4'd5 && wr_addr < 4'd12)
        m_reg[wr_addr] = wr_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      int tp;
      tp = m_top();
      chk("R10 msg_valid", {31'd0, msg_valid}, {31'd0, tp >= 0});
      if (tp >= 0) chk("R10 msg_type", {30'd0, msg_type}, tp);
      chk("R3 rd_data vs model", rd_data, m_read(rd_addr));
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic mv(input string tag, input logic v, input logic [1:0] t);
    chk(tag, {31'd0, msg_valid}, {31'd0, v});
    if (v) chk(tag, {30'd0, msg_type}, {30'd0, t});
  endtask

  task automatic take();
    msg_ready = 1; tick(); msg_ready = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1
    for (int a = 0; a < 12; a++) rd("R1 reset value", 4'(a), 32'd0);
    mv("R1 msg_valid idle", 1'b0, 2'd0);

    // R2, R11
    wr(4'd7, 32'h1);
    rd("R11 emu latched", 4'd7, 32'h1);
    tick();
    rd("R11 self-clear", 4'd7, 32'h0);
    rd("R2 ce status", 4'd3, 32'h1);
    mv("R2 cor request", 1'b1, 2'd0);
    take();
    mv("R10 retired", 1'b0, 2'd0);

    // R7 clear
    wr(4'd3, 32'h1);
    rd("R7 w1c ce", 4'd3, 32'h0);

    // R4 masked
    wr(4'd1, 32'h10);
    wr(4'd6, 32'h10);
    tick();
    rd("R4 masked status", 4'd0, 32'h10);
    mv("R4 no request", 1'b0, 2'd0);
    rd("R8 masked not pointed", 4'd5, 32'h0);

    // R5, R3, R8, R10
    wr(4'd2, 32'h40);
    wr(4'd6, 32'h20);
    tick();
    mv("R5 nonfatal", 1'b1, 2'd1);
    rd("R8 pointer set", 4'd5, 32'h8000_0005);
    wr(4'd6, 32'h40);
    tick();
    rd("R3 ue status", 4'd0, 32'h70);
    mv("R5 fatal first (R10)", 1'b1, 2'd2);
    rd("R8 pointer held", 4'd5, 32'h8000_0005);
    take();
    mv("R10 nonfatal next", 1'b1, 2'd1);
    take();
    mv("R10 drained", 1'b0, 2'd0);
    wr(4'd0, 32'h20);
    rd("R8 pointer released", 4'd5, 32'h0000_0005);

    // R6 advisory
    wr(4'd6, 32'h8000_0080);
    tick();
    rd("R6 ue status", 4'd0, 32'hD0);
    rd("R6 ce advisory bit", 4'd3, 32'h2000);
    mv("R6 cor request", 1'b1, 2'd0);
    rd("R8 pointer advisory", 4'd5, 32'h8000_0007);
    take();
    wr(4'd4, 32'h2000);
    wr(4'd6, 32'h8000_0100);
    tick();
    mv("R6 masked advisory", 1'b0, 2'd0);
    rd("R6 ue status 2", 4'd0, 32'h1D0);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd6, 32'h8000_0000);
    tick();
    rd("R6 qualifier alone ue", 4'd0, 32'h0);
    rd("R6 qualifier alone ce", 4'd3, 32'h0);
    mv("R6 qualifier alone msg", 1'b0, 2'd0);

    // R7 set wins over clear
    wr(4'd6, 32'h200);
    wr(4'd0, 32'h200);
    rd("R7 set wins", 4'd0, 32'h200);
    mv("R5 nonfatal bit9", 1'b1, 2'd1);
    take();

    // R9
    wr(4'd8,  32'hA5A5_0001);
    wr(4'd9,  32'h1234_5678);
    wr(4'd10, 32'hDEAD_BEEF);
    wr(4'd11, 32'h0F0F_F0F0);
    rd("R9 hdr0", 4'd8,  32'hA5A5_0001);
    rd("R9 hdr1", 4'd9,  32'h1234_5678);
    rd("R9 hdr2", 4'd10, 32'hDEAD_BEEF);
    rd("R9 hdr3", 4'd11, 32'h0F0F_F0F0);
    rd("R9 status untouched", 4'd0, 32'h200);

    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule